// File: doc/BRIEF.md
# Debug Fault Qualifier and Syndrome Builder

This block sits at the exception stage of a processor pipeline. It receives breakpoint-match strobes from the instruction-fetch side and the data-access side, along with qualifiers that describe the data access. Each strobe is gated by the processor-status debug enables. The block then picks one of three debug interruption kinds: instruction debug, data debug, or register-stack data debug. For the chosen kind it registers a fault report made of a vector offset, a faulting address, a 64-bit syndrome word, and the captured instruction bundle together with its valid flag.

All three kinds report through one vector offset. Instruction-side events and data-side events are suppressed by different status bits. The syndrome layout is fixed, so the handler can decode the access type without further state. When both sides match in the same cycle, the instruction event is reported, because it belongs to the earlier stage.

Top module: `dbg_fault_unit`

## Requirements
- R1: A taken fault raises `flt_valid` for exactly one cycle, on the clock edge that samples the match, and `flt_vector` then reads 0x5900. With no taken fault in a cycle, `flt_valid` is 0 in the following cycle.
- R2: An instruction match is suppressed when `st_db` is 0 or `st_id` is 1. `st_dd` has no effect on it.
- R3: A data match is suppressed when `st_db` is 0 or `st_dd` is 1. `st_id` has no effect on it.
- R4: When an unsuppressed instruction match and a data match arrive in the same cycle, the instruction fault is reported. If the instruction match is suppressed, the data fault is reported.
- R5: `flt_addr` carries `ifetch_addr` for an instruction fault and `data_addr` for either data kind.
- R6: `flt_bundle_valid` is 1 only for a data debug fault, and `flt_bundle` then carries `bundle_in`. For every other kind both are 0.
- R7: The data syndrome uses these bits: w in bit 33, r in bit 34, na in bit 35, sp in bit 36, rs in bit 37, ir in bit 38, ni in bit 39, the slot index in bits 42:41, and ed in bit 43. All other bits are 0, including bit 32.
- R8: A data match with `data_rse` = 1 (a mandatory register-stack fill or spill) is reported as the register-stack data debug kind, and ed (bit 43) is forced to 0.
- R9: The instruction syndrome sets bit 32 (execute), puts `ifetch_slot` in bits 42:41 and `ifetch_ni` in bit 39. Every other bit is 0.
- R10: A data match flagged non-access (`data_na` = 1) raises a fault only when `data_fault_op` = 1, which marks a faulting probe or faulting prefetch. Otherwise the match is ignored.
- R11: `flt_kind` encodes the reported kind as 1 for instruction, 2 for data, 3 for register-stack data, and 0 when no fault is reported.
- R12: While `rst_n` is low, all outputs are 0. Reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifetch_hit | input | 1 | Instruction breakpoint match |
| ifetch_addr | input | ADDR_W | Instruction fetch address |
| ifetch_slot | input | 2 | Slot of the faulting instruction |
| ifetch_ni | input | 1 | ni flag for an instruction fault |
| data_hit | input | 1 | Data breakpoint match |
| data_addr | input | ADDR_W | Referenced data address |
| data_wr | input | 1 | Access is a write |
| data_rd | input | 1 | Access is a read |
| data_na | input | 1 | Non-access operation |
| data_fault_op | input | 1 | Non-access operation is a faulting probe or prefetch |
| data_spec | input | 1 | Speculative access |
| data_rse | input | 1 | Mandatory register-stack fill or spill |
| data_ir | input | 1 | ir flag for the syndrome |
| data_ni | input | 1 | ni flag for a data fault |
| data_slot | input | 2 | Slot of the data-access instruction |
| data_ed | input | 1 | ed flag for a data fault |
| st_db | input | 1 | Status: debug faults enabled |
| st_id | input | 1 | Status: instruction debug disabled |
| st_dd | input | 1 | Status: data debug disabled |
| bundle_in | input | BUNDLE_WORDS*WORD_W | Instruction bundle words |
| flt_valid | output | 1 | One-cycle fault report strobe |
| flt_vector | output | 16 | Vector offset |
| flt_kind | output | 2 | Reported fault kind |
| flt_addr | output | ADDR_W | Faulting address |
| flt_syn | output | 64 | Syndrome word |
| flt_bundle_valid | output | 1 | Captured bundle is valid |
| flt_bundle | output | BUNDLE_WORDS*WORD_W | Captured bundle |

## Verification
Every result (strobe, kind, vector, address, syndrome and bundle) passes through exactly one register. Each is therefore due on the first rising edge after the inputs are driven. The bench drives inputs on the falling edge and samples all outputs on the next falling edge, after one rising edge has passed. It checks, one cycle after a taken fault is followed by an idle cycle, that the strobe has dropped again. Reset is checked a moment after `rst_n` falls, with no clock edge in between, so that the asynchronous clear is seen on its own.

// File: rtl/dbg_fault_pkg.sv
package dbg_fault_pkg;

    localparam logic [15:0] VEC_OFFSET = 16'h5900;
    localparam int SYN_W   = 64;
    localparam int SLOT_W  = 2;

    // syndrome bit positions decoded by the handler
    localparam int SB_X    = 32;
    localparam int SB_W    = 33;
    localparam int SB_R    = 34;
    localparam int SB_NA   = 35;
    localparam int SB_SP   = 36;
    localparam int SB_RS   = 37;
    localparam int SB_IR   = 38;
    localparam int SB_NI   = 39;
    localparam int SB_EI   = 41;
    localparam int SB_ED   = 43;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_INSTR  = 2'd1,
        KIND_DATA   = 2'd2,
        KIND_IRDATA = 2'd3
    } fault_kind_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic na;
        logic spec;
        logic rse;
        logic ir;
        logic ni;
        logic ed;
        logic [SLOT_W-1:0] slot;
    } data_qual_t;

endpackage

// File: rtl/dbg_fault_gate.sv
module dbg_fault_gate
    import dbg_fault_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ifetch_hit,
    input  logic        data_hit,
    input  logic        data_na,
    input  logic        data_fault_op,
    input  logic        data_rse,
    input  logic        st_db,
    input  logic        st_id,
    input  logic        st_dd,
    output fault_kind_e kind
);

    logic instr_ok;
    logic data_ok;
    logic na_ok;

    always_comb begin
        instr_ok = ifetch_hit && st_db && !st_id;
        na_ok    = !data_na || data_fault_op;
        data_ok  = data_hit && st_db && !st_dd && na_ok;
        if (instr_ok) begin
            kind = KIND_INSTR;
        end else if (data_ok) begin
            kind = data_rse ? KIND_IRDATA : KIND_DATA;
        end else begin
            kind = KIND_NONE;
        end
    end

    // R10: plain non-access matches never reach the data side
    assert_nonaccess_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && data_na && !data_fault_op && !ifetch_hit) |-> (kind == KIND_NONE));

    // R4: an enabled instruction match always outranks the data side
    assert_instr_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ifetch_hit && st_db && !st_id && data_hit) |-> (kind == KIND_INSTR));

endmodule

// File: rtl/dbg_fault_syndrome.sv
module dbg_fault_syndrome
    import dbg_fault_pkg::*;
(
    input  fault_kind_e        kind,
    input  logic [SLOT_W-1:0]  ifetch_slot,
    input  logic               ifetch_ni,
    input  data_qual_t         dq,
    output logic [SYN_W-1:0]   syn
);

    always_comb begin
        syn = '0;
        unique case (kind)
            KIND_INSTR: begin
                syn[SB_X]               = 1'b1;
                syn[SB_NI]              = ifetch_ni;
                syn[SB_EI +: SLOT_W]    = ifetch_slot;
            end
            KIND_DATA, KIND_IRDATA: begin
                syn[SB_W]               = dq.wr;
                syn[SB_R]               = dq.rd;
                syn[SB_NA]              = dq.na;
                syn[SB_SP]              = dq.spec;
                syn[SB_RS]              = dq.rse;
                syn[SB_IR]              = dq.ir;
                syn[SB_NI]              = dq.ni;
                syn[SB_EI +: SLOT_W]    = dq.slot;
                syn[SB_ED]              = (kind == KIND_IRDATA) ? 1'b0 : dq.ed;
            end
            default: syn = '0;
        endcase
    end

endmodule

// File: rtl/dbg_fault_unit.sv
module dbg_fault_unit
    import dbg_fault_pkg::*;
#(
    parameter int ADDR_W       = 64,
    parameter int WORD_W       = 64,
    parameter int BUNDLE_WORDS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ifetch_hit,
    input  logic [ADDR_W-1:0]              ifetch_addr,
    input  logic [1:0]                     ifetch_slot,
    input  logic                           ifetch_ni,
    input  logic                           data_hit,
    input  logic [ADDR_W-1:0]              data_addr,
    input  logic                           data_wr,
    input  logic                           data_rd,
    input  logic                           data_na,
    input  logic                           data_fault_op,
    input  logic                           data_spec,
    input  logic                           data_rse,
    input  logic                           data_ir,
    input  logic                           data_ni,
    input  logic [1:0]                     data_slot,
    input  logic                           data_ed,
    input  logic                           st_db,
    input  logic                           st_id,
    input  logic                           st_dd,
    input  logic [BUNDLE_WORDS*WORD_W-1:0] bundle_in,
    output logic                           flt_valid,
    output logic [15:0]                    flt_vector,
    output logic [1:0]                     flt_kind,
    output logic [ADDR_W-1:0]              flt_addr,
    output logic [63:0]                    flt_syn,
    output logic                           flt_bundle_valid,
    output logic [BUNDLE_WORDS*WORD_W-1:0] flt_bundle
);

    localparam int BUNDLE_W = BUNDLE_WORDS * WORD_W;

    typedef struct packed {
        logic                valid;
        logic [15:0]         vector;
        fault_kind_e         kind;
        logic [ADDR_W-1:0]   addr;
        logic [SYN_W-1:0]    syn;
        logic                bvalid;
        logic [BUNDLE_W-1:0] bundle;
    } report_t;

    fault_kind_e          kind_w;
    logic [SYN_W-1:0]     syn_w;
    data_qual_t           dq;
    logic                 keep_bundle;
    logic [BUNDLE_W-1:0]  bundle_w;
    report_t              rep_d, rep_q;

    always_comb begin
        dq.wr   = data_wr;
        dq.rd   = data_rd;
        dq.na   = data_na;
        dq.spec = data_spec;
        dq.rse  = data_rse;
        dq.ir   = data_ir;
        dq.ni   = data_ni;
        dq.ed   = data_ed;
        dq.slot = data_slot;
    end

    dbg_fault_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .ifetch_hit    (ifetch_hit),
        .data_hit      (data_hit),
        .data_na       (data_na),
        .data_fault_op (data_fault_op),
        .data_rse      (data_rse),
        .st_db         (st_db),
        .st_id         (st_id),
        .st_dd         (st_dd),
        .kind          (kind_w)
    );

    dbg_fault_syndrome u_syn (
        .kind        (kind_w),
        .ifetch_slot (ifetch_slot),
        .ifetch_ni   (ifetch_ni),
        .dq          (dq),
        .syn         (syn_w)
    );

    assign keep_bundle = (kind_w == KIND_DATA);

    // per-word bundle capture, cleared for kinds without a valid bundle
    for (genvar gi = 0; gi < BUNDLE_WORDS; gi++) begin : g_bundle
        assign bundle_w[gi*WORD_W +: WORD_W] =
            keep_bundle ? bundle_in[gi*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        rep_d = '0;
        if (kind_w != KIND_NONE) begin
            rep_d.valid  = 1'b1;
            rep_d.vector = VEC_OFFSET;
            rep_d.kind   = kind_w;
            rep_d.addr   = (kind_w == KIND_INSTR) ? ifetch_addr : data_addr;
            rep_d.syn    = syn_w;
            rep_d.bvalid = keep_bundle;
            rep_d.bundle = bundle_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign flt_valid        = rep_q.valid;
    assign flt_vector       = rep_q.vector;
    assign flt_kind         = rep_q.kind;
    assign flt_addr         = rep_q.addr;
    assign flt_syn          = rep_q.syn;
    assign flt_bundle_valid = rep_q.bvalid;
    assign flt_bundle       = rep_q.bundle;

    assert_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_vector == 16'h5900));

    assert_strobe_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ($past(ifetch_hit) || $past(data_hit)));

    assert_instr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_kind == KIND_INSTR) |-> ($past(st_db) && !$past(st_id)));

    assert_data_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_kind[1]) |-> ($past(st_db) && !$past(st_dd)));

    assert_bundle_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flt_bundle_valid |-> (flt_kind == KIND_DATA));

    assert_rse_ed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_kind == KIND_IRDATA) |-> !flt_syn[SB_ED]);

    assert_instr_syn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_kind == KIND_INSTR) |-> (flt_syn[SB_X] && flt_syn[SB_IR:SB_W] == '0 && !flt_syn[SB_ED]));

    assert_kind_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid == (flt_kind != KIND_NONE));

endmodule

// File: tb/dbg_fault_unit_test.sv
`timescale 1ns/1ps
module dbg_fault_unit_test;

    localparam int AW = 64;
    localparam int BW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ifetch_hit = 0, ifetch_ni = 0, data_hit = 0;
    logic [AW-1:0] ifetch_addr = '0, data_addr = '0;
    logic [1:0] ifetch_slot = '0, data_slot = '0;
    logic data_wr = 0, data_rd = 0, data_na = 0, data_fault_op = 0, data_spec = 0;
    logic data_rse = 0, data_ir = 0, data_ni = 0, data_ed = 0;
    logic st_db = 0, st_id = 0, st_dd = 0;
    logic [BW-1:0] bundle_in = '0;
    logic flt_valid, flt_bundle_valid;
    logic [15:0] flt_vector;
    logic [1:0] flt_kind;
    logic [AW-1:0] flt_addr;
    logic [63:0] flt_syn;
    logic [BW-1:0] flt_bundle;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    dbg_fault_unit uut (
        .clk(clk), .rst_n(rst_n),
        .ifetch_hit(ifetch_hit), .ifetch_addr(ifetch_addr), .ifetch_slot(ifetch_slot), .ifetch_ni(ifetch_ni),
        .data_hit(data_hit), .data_addr(data_addr), .data_wr(data_wr), .data_rd(data_rd),
        .data_na(data_na), .data_fault_op(data_fault_op), .data_spec(data_spec), .data_rse(data_rse),
        .data_ir(data_ir), .data_ni(data_ni), .data_slot(data_slot), .data_ed(data_ed),
        .st_db(st_db), .st_id(st_id), .st_dd(st_dd), .bundle_in(bundle_in),
        .flt_valid(flt_valid), .flt_vector(flt_vector), .flt_kind(flt_kind), .flt_addr(flt_addr),
        .flt_syn(flt_syn), .flt_bundle_valid(flt_bundle_valid), .flt_bundle(flt_bundle)
    );

    typedef struct packed {
        logic ih, dh, db, id, dd, w, r, na, fop, sp, rse, ir, dni, ini;
        logic [1:0] islot, dslot;
        logic ed;
        logic [1:0] ek;
    } vec_t;

    localparam int NV = 15;
    //  ih dh db id dd  w  r na fop sp rse ir dni ini islot dslot ed ek
    localparam vec_t TABLE [NV] = '{
        '{0,0,1,0,0, 0,0,0,0,0,0,0,0,0, 2'd0,2'd0,0, 2'd0},
        '{1,0,1,0,0, 0,0,0,0,0,0,0,0,1, 2'd2,2'd0,0, 2'd1},
        '{1,0,0,0,0, 0,0,0,0,0,0,0,0,1, 2'd1,2'd0,0, 2'd0},
        '{1,0,1,1,0, 0,0,0,0,0,0,0,0,0, 2'd1,2'd0,0, 2'd0},
        '{0,1,1,0,0, 0,1,0,0,0,0,0,0,0, 2'd0,2'd1,1, 2'd2},
        '{0,1,1,0,1, 0,1,0,0,0,0,0,0,0, 2'd0,2'd1,0, 2'd0},
        '{0,1,1,1,0, 1,0,0,0,0,0,0,0,0, 2'd0,2'd2,0, 2'd2},
        '{0,1,1,0,0, 0,0,1,0,0,0,0,0,0, 2'd0,2'd0,0, 2'd0},
        '{0,1,1,0,0, 0,1,1,1,0,0,0,0,0, 2'd0,2'd0,0, 2'd2},
        '{0,1,1,0,0, 1,0,0,0,1,1,0,0,0, 2'd0,2'd3,1, 2'd3},
        '{1,1,1,0,0, 0,1,0,0,0,0,0,0,1, 2'd1,2'd2,1, 2'd1},
        '{1,1,1,1,0, 1,0,0,0,0,0,0,1,0, 2'd2,2'd0,1, 2'd2},
        '{0,1,0,0,0, 1,0,0,0,0,0,0,0,0, 2'd0,2'd0,0, 2'd0},
        '{0,1,1,0,0, 1,1,0,0,1,0,1,1,0, 2'd0,2'd3,1, 2'd2},
        '{1,0,1,0,1, 0,0,0,0,0,0,0,0,0, 2'd3,2'd0,0, 2'd1}
    };

    localparam logic [BW-1:0] BUNDLE = 128'hA5A5_0123_4567_89AB_CDEF_FEDC_BA98_5A5A;

    function automatic logic [AW-1:0] iaddr_of(int i);
        return 64'h0000_4000_0000_1000 + 64'(i * 16);
    endfunction
    function automatic logic [AW-1:0] daddr_of(int i);
        return 64'hFFFF_0000_0000_0000 | 64'(i);
    endfunction

    function automatic logic [63:0] exp_syn(vec_t v);
        logic [63:0] s = '0;
        if (v.ek == 2'd1) begin
            s[32] = 1'b1; s[39] = v.ini; s[42:41] = v.islot;
        end else if (v.ek != 2'd0) begin
            s[33] = v.w; s[34] = v.r; s[35] = v.na; s[36] = v.sp;
            s[37] = v.rse; s[38] = v.ir; s[39] = v.dni; s[42:41] = v.dslot;
            s[43] = (v.ek == 2'd3) ? 1'b0 : v.ed;
        end
        return s;
    endfunction

    task automatic chk(string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v, int i);
        ifetch_hit = v.ih; data_hit = v.dh; st_db = v.db; st_id = v.id; st_dd = v.dd;
        data_wr = v.w; data_rd = v.r; data_na = v.na; data_fault_op = v.fop; data_spec = v.sp;
        data_rse = v.rse; data_ir = v.ir; data_ni = v.dni; ifetch_ni = v.ini;
        ifetch_slot = v.islot; data_slot = v.dslot; data_ed = v.ed;
        ifetch_addr = iaddr_of(i); data_addr = daddr_of(i); bundle_in = BUNDLE;
    endtask

    task automatic idle();
        ifetch_hit = 0; data_hit = 0;
    endtask

    task automatic check_report(vec_t v, int i, string req);
        logic [AW-1:0] ea;
        ea = (v.ek == 2'd0) ? '0 : (v.ek == 2'd1) ? iaddr_of(i) : daddr_of(i);
        chk(req, "valid R1", BW'(flt_valid), BW'(v.ek != 2'd0));
        chk(req, "kind R11", BW'(flt_kind), BW'(v.ek));
        chk(req, "vector R1", BW'(flt_vector), (v.ek != 2'd0) ? BW'(16'h5900) : '0);
        chk(req, "addr R5", BW'(flt_addr), BW'(ea));
        chk(req, "syndrome R7/R9", BW'(flt_syn), BW'(exp_syn(v)));
        chk(req, "bundle_valid R6", BW'(flt_bundle_valid), BW'(v.ek == 2'd2));
        chk(req, "bundle R6", flt_bundle, (v.ek == 2'd2) ? BUNDLE : '0);
    endtask

    task automatic check_zero(string req);
        chk(req, "valid", BW'(flt_valid), '0);
        chk(req, "kind", BW'(flt_kind), '0);
        chk(req, "vector", BW'(flt_vector), '0);
        chk(req, "addr", BW'(flt_addr), '0);
        chk(req, "syndrome", BW'(flt_syn), '0);
        chk(req, "bundle_valid", BW'(flt_bundle_valid), '0);
        chk(req, "bundle", flt_bundle, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check_zero("R12 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: drive on a falling edge, check one rising edge later
        for (int i = 0; i < NV; i++) begin
            drive(TABLE[i], i);
            @(negedge clk);
            check_report(TABLE[i], i, $sformatf("R2/R3/R4/R8/R10 vec%0d", i));
        end

        // R1: strobe lasts one cycle after a single match
        drive(TABLE[1], 1);
        @(negedge clk);
        chk("R1 strobe rise", "valid", BW'(flt_valid), BW'(1));
        idle();
        @(negedge clk);
        chk("R1 strobe drop", "valid", BW'(flt_valid), '0);
        chk("R1 strobe drop", "vector", BW'(flt_vector), '0);

        // R1: back-to-back matches give back-to-back reports
        drive(TABLE[4], 4);
        @(negedge clk);
        check_report(TABLE[4], 4, "R1 b2b first");
        drive(TABLE[9], 9);
        @(negedge clk);
        check_report(TABLE[9], 9, "R1 b2b second R8");
        idle();
        @(negedge clk);
        chk("R1 b2b end", "valid", BW'(flt_valid), '0);

        // R12: asynchronous reset clears a pending report
        drive(TABLE[13], 13);
        @(negedge clk);
        chk("R12 pre", "valid", BW'(flt_valid), BW'(1));
        idle();
        #1 rst_n = 1'b0;
        #1 check_zero("R12 async");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("R12 after");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule